// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address from an instruction fetch, a load or a store into a physical address. The table that holds the mapping lives in ordinary physical memory, so every request costs one table walk. The upper bits of the virtual address select a table slot. The lower bits are the byte offset inside a page. The slot address is the table base plus four bytes for each page number. The base is held in a register that software loads through a one-cycle write port.

The entry comes back over a single-word read port after any number of cycles. The block then inspects it. A cleared present flag gives a not-present fault. A present entry that lacks the permission for the request kind gives a protection fault. Otherwise the physical page number is joined with the untouched offset. Only one request is in flight at a time. Changing the base register switches to another address space, and the change applies from the next accepted request on.

Top module: `vmt_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. The table base register resets to 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `mem_rd_en` is high for exactly one cycle. `mem_rd_addr` then equals base + 4 × page number, where the page number is `req_vaddr[VPN_W+OFF_W-1:OFF_W]`.
- R3: Entry layout: bit 31 is present, bit 30 is read, bit 29 is write, bit 28 is execute, and bits PPN_W-1:0 hold the physical page number. On success, `rsp_fault` is 00 and `rsp_paddr` = {page number, `req_vaddr[OFF_W-1:0]`}.
- R4: An entry whose bit 31 is 0 gives `rsp_fault` = 01 and `rsp_paddr` = 0.
- R5: Request kind 00 (load) and 11 (treated as a load) need the read bit. Kind 01 (store) needs the write bit. Kind 10 (fetch) needs the execute bit. If a present entry lacks the needed bit, the result is `rsp_fault` = 10 and `rsp_paddr` = 0.
- R6: On an absent entry the permission bits are ignored: the fault is 01 even when all three permission bits are set.
- R7: `req_ready` is low from the cycle after acceptance up to and including the response cycle. `rsp_valid` is a one-cycle pulse in the cycle after the edge that samples `mem_rd_valid`. `req_ready` is high again in the cycle after the response.
- R8: The block waits any number of cycles for `mem_rd_valid`, including a strobe in the same cycle as `mem_rd_en`. A `mem_rd_valid` strobe while no walk is in progress has no effect.
- R9: A base write is used by requests accepted after the write's edge. A write in the same cycle as an acceptance, or during a walk, leaves that walk's read address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PPN_W+OFF_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| ptbr_we | input | 1 | Table base write strobe |
| ptbr_wdata | input | AW | New table base |
| mem_rd_en | output | 1 | Entry read request |
| mem_rd_addr | output | AW | Entry byte address |
| mem_rd_valid | input | 1 | Entry data strobe |
| mem_rd_data | input | 32 | Entry data |

## Verification
Two things can land on the same clock edge: a base-register write and the acceptance of a request. A base write can also arrive while a walk waits on memory. The bench provokes both by raising `ptbr_we` in the acceptance cycle of one request, and in the issue cycle of the next. It judges each case by the read address that request presents. That address must still be built from the old base. The request that follows must use the newly written base.

// File: rtl/vmt_pkg.sv
package vmt_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'b00,
    ACC_STORE    = 2'b01,
    ACC_FETCH    = 2'b10,
    ACC_LOAD_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  localparam int PTE_W     = 32;
  localparam int PTE_VALID = 31;
  localparam int PTE_RD    = 30;
  localparam int PTE_WR    = 29;
  localparam int PTE_EX    = 28;
  localparam int PTE_SHIFT = 2;   // entries are 4 bytes apart

endpackage

// File: rtl/vmt_index.sv
module vmt_index #(
  parameter int VPN_W = 5,
  parameter int AW    = 32
) (
  input  logic [AW-1:0]    base,
  input  logic [VPN_W-1:0] vpn,
  output logic [AW-1:0]    entry_addr
);
  import vmt_pkg::*;

  logic [AW-1:0] slot_offs;

  always_comb begin
    slot_offs  = AW'(vpn) << PTE_SHIFT;
    entry_addr = base + slot_offs;
  end

endmodule

// File: rtl/vmt_rights.sv
module vmt_rights #(
  parameter int OFF_W = 10,
  parameter int PPN_W = 5,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic [vmt_pkg::PTE_W-1:0] pte,
  input  logic [1:0]                kind,
  input  logic [OFF_W-1:0]          offset,
  output vmt_pkg::fault_e           fault,
  output logic [PA_W-1:0]           paddr
);
  import vmt_pkg::*;

  logic allowed;
  logic unused_pte_bits;

  assign unused_pte_bits = ^pte[PTE_EX-1:PPN_W];

  always_comb begin
    case (acc_kind_e'(kind))
      ACC_STORE: allowed = pte[PTE_WR];
      ACC_FETCH: allowed = pte[PTE_EX];
      default:   allowed = pte[PTE_RD];
    endcase

    if (!pte[PTE_VALID]) begin
      fault = FLT_ABSENT;
    end else if (!allowed) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end

    if (fault == FLT_NONE) begin
      paddr = {pte[PPN_W-1:0], offset};
    end else begin
      paddr = '0;
    end
  end

endmodule

// File: rtl/vmt_ctrl.sv
module vmt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rd_valid,
  output logic req_ready,
  output logic accept,
  output logic rd_en,
  output logic capture,
  output logic rsp_valid
);
  import vmt_pkg::*;

  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_ISSUE;
      ST_ISSUE: st_d = rd_valid ? ST_DONE : ST_WAIT;
      ST_WAIT:  if (rd_valid) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_en     = (st_q == ST_ISSUE);
  assign capture   = ((st_q == ST_ISSUE) || (st_q == ST_WAIT)) && rd_valid;
  assign rsp_valid = (st_q == ST_DONE);

  a_r2_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_en);

  a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r8_capture_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> rsp_valid);

  a_r8_idle_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !rd_en && !rsp_valid);

endmodule

// File: rtl/vmt_top.sv
module vmt_top #(
  parameter int VPN_W = 5,
  parameter int OFF_W = 10,
  parameter int PPN_W = 5,
  parameter int AW    = 32,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  input  logic            ptbr_we,
  input  logic [AW-1:0]   ptbr_wdata,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [31:0]     mem_rd_data
);
  import vmt_pkg::*;

  logic              accept;
  logic              capture;
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     entry_addr;
  logic [AW-1:0]     walk_addr_q;
  logic [1:0]        kind_q;
  logic [OFF_W-1:0]  off_q;
  logic [PTE_W-1:0]  pte_q;
  fault_e            fault;

  vmt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rd_valid  (mem_rd_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_en     (mem_rd_en),
    .capture   (capture),
    .rsp_valid (rsp_valid)
  );

  vmt_index #(.VPN_W(VPN_W), .AW(AW)) u_index (
    .base       (base_q),
    .vpn        (req_vaddr[VA_W-1:OFF_W]),
    .entry_addr (entry_addr)
  );

  // Table base: a write lands at the edge, so an acceptance on the
  // same edge still sees the previous base.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (ptbr_we) begin
      base_q <= ptbr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_addr_q <= '0;
      kind_q      <= '0;
      off_q       <= '0;
    end else if (accept) begin
      walk_addr_q <= entry_addr;
      kind_q      <= req_kind;
      off_q       <= req_vaddr[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (capture) begin
      pte_q <= mem_rd_data;
    end
  end

  vmt_rights #(.OFF_W(OFF_W), .PPN_W(PPN_W)) u_rights (
    .pte    (pte_q),
    .kind   (kind_q),
    .offset (off_q),
    .fault  (fault),
    .paddr  (rsp_paddr)
  );

  assign mem_rd_addr = walk_addr_q;
  assign rsp_fault   = fault;

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_paddr[OFF_W-1:0] == off_q);

  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> rsp_paddr == '0);

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(mem_rd_addr));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || rsp_valid) |-> !req_ready);

endmodule

// File: tb/vmt_top_tb.sv
`timescale 1ns/1ps
module vmt_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [14:0] req_vaddr;
  logic        rsp_valid;
  logic [14:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        ptbr_we;
  logic [31:0] ptbr_wdata;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  vmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .ptbr_we(ptbr_we),
    .ptbr_wdata(ptbr_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [14:0] va;
    logic [31:0] pte;
    logic [3:0]  lat;
    logic [1:0]  fault;
    logic [14:0] pa;
  } vec_t;

  // kind, vaddr, entry, latency, expected fault, expected paddr
  localparam vec_t VECS [9] = '{
    '{2'b00, 15'h0C55, 32'hC000001F, 4'd1, 2'b00, 15'h7C55},  // R3 load, page 31
    '{2'b01, 15'h7FFF, 32'hE0000004, 4'd3, 2'b00, 15'h13FF},  // R3 store, last page
    '{2'b10, 15'h0401, 32'h90000002, 4'd0, 2'b00, 15'h0801},  // R8 zero latency fetch
    '{2'b01, 15'h0800, 32'hC0000005, 4'd1, 2'b10, 15'h0000},  // R5 store to read-only
    '{2'b10, 15'h1010, 32'hE0000006, 4'd5, 2'b10, 15'h0000},  // R5 fetch, no execute
    '{2'b00, 15'h2000, 32'h70000007, 4'd1, 2'b01, 15'h0000},  // R6 absent, all rights
    '{2'b00, 15'h0000, 32'hA0000001, 4'd2, 2'b10, 15'h0000},  // R5 load, no read
    '{2'b11, 15'h0C21, 32'hC0000003, 4'd1, 2'b00, 15'h0C21},  // R5 kind 11 as load
    '{2'b01, 15'h3C00, 32'h20000009, 4'd4, 2'b01, 15'h0000}   // R4 absent store
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  task automatic do_txn(input logic [1:0] kind, input logic [14:0] va,
                        input logic [31:0] pte, input int lat,
                        input logic [1:0] ef, input logic [14:0] epa,
                        input logic [31:0] ebase, input bit acc_wr,
                        input bit mid_wr, input logic [31:0] wr_val,
                        input string tag);
    logic [31:0] eaddr;
    eaddr = ebase + ({27'd0, va[14:10]} << 2);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_kind  = kind;
    req_vaddr = va;
    if (acc_wr) begin
      ptbr_we    = 1'b1;
      ptbr_wdata = wr_val;
    end
    @(negedge clk);
    req_valid = 1'b0;
    ptbr_we   = 1'b0;
    chk(mem_rd_en == 1'b1, "R2 read issued", 32'(mem_rd_en), 32'd1);
    chk(mem_rd_addr == eaddr, {"R2 R9 entry address ", tag}, mem_rd_addr, eaddr);
    chk(req_ready == 1'b0, "R7 busy", 32'(req_ready), 32'd0);
    if (mid_wr) begin
      ptbr_we    = 1'b1;
      ptbr_wdata = wr_val;
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      ptbr_we = 1'b0;
      chk(mem_rd_en == 1'b0, "R2 single read", 32'(mem_rd_en), 32'd0);
      chk(rsp_valid == 1'b0, "R8 waits for memory", 32'(rsp_valid), 32'd0);
    end
    mem_rd_valid = 1'b1;
    mem_rd_data  = pte;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    mem_rd_data  = 32'hDEADBEEF;
    ptbr_we      = 1'b0;
    chk(rsp_valid == 1'b1, "R7 response pulse", 32'(rsp_valid), 32'd1);
    chk(rsp_fault == ef, {"fault ", tag}, 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr == epa, {"paddr ", tag}, 32'(rsp_paddr), 32'(epa));
    chk(req_ready == 1'b0, "R7 ready low in response", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 pulse ends", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R7 ready back", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_kind     = 2'b00;
    req_vaddr    = '0;
    ptbr_we      = 1'b0;
    ptbr_wdata   = '0;
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R1 reset rd_en", 32'(mem_rd_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0,
        "R1 idle after reset", {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'h4);

    // R1: base resets to zero, so page 5 sits at byte 0x14
    do_txn(2'b00, 15'h1400, 32'hC0000001, 1, 2'b00, 15'h0400,
           32'h0, 1'b0, 1'b0, 32'h0, "R1 zero base");

    // R8: stray strobe while idle does nothing
    mem_rd_valid = 1'b1;
    mem_rd_data  = 32'hC000001F;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0 && mem_rd_en == 1'b0 && req_ready == 1'b1,
          "R8 idle strobe ignored", {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'h4);
    end
    mem_rd_valid = 1'b0;

    @(negedge clk);
    ptbr_we    = 1'b1;
    ptbr_wdata = 32'h0000_1000;
    @(negedge clk);
    ptbr_we = 1'b0;

    for (int v = 0; v < 9; v++) begin
      do_txn(VECS[v].kind, VECS[v].va, VECS[v].pte, int'(VECS[v].lat),
             VECS[v].fault, VECS[v].pa, 32'h1000, 1'b0, 1'b0, 32'h0,
             $sformatf("R3 R4 R5 vector %0d", v));
    end

    // R9: base write in the acceptance cycle keeps the old base
    do_txn(2'b00, 15'h0C00, 32'hC0000002, 1, 2'b00, 15'h0800,
           32'h1000, 1'b1, 1'b0, 32'h2000, "R9 write at accept");
    // R9: base write during a walk keeps that walk's base
    do_txn(2'b01, 15'h0400, 32'hA0000003, 2, 2'b00, 15'h0C00,
           32'h2000, 1'b0, 1'b1, 32'h3000, "R9 write mid walk");
    // R9: next request sees the newest base
    do_txn(2'b10, 15'h7C10, 32'h90000001, 1, 2'b00, 15'h0410,
           32'h3000, 1'b0, 1'b0, 32'h0, "R9 new base used");

    summary();
    $finish;
  end

endmodule